// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

This block chooses which of eight interrupt request lines is served next and decides whether that request may interrupt the handler now running. Each source has a 4-bit priority word. A global group setting splits the word at run time into an upper preemption field and a lower sub-priority field. Only the preemption field decides nesting. The sub-priority field, and after it the source index, only break ties among requests that are pending at the same moment.

Request lines are sampled as levels into a pending register. When the arbiter accepts a request it raises a one-cycle take pulse that carries the source index. In the same cycle it clears that pending bit and pushes the preemption level of the request onto an active-level stack. A handler-complete strobe pops the stack. Arbitration then continues against the level that was restored, so nested handlers unwind in order.

Top module: `grp_irq_arb`

## Requirements
- R1: After reset no request is pending, `take_o` is low, no handler is active and the group setting is 0.
- R2: A request line that is high at a clock edge sets its pending bit. The bit stays set after the line drops and is cleared only when that source is taken.
- R3: Among pending requests the winner has the numerically smallest priority word. A smaller value means higher priority, so the preemption field is compared first and the sub-priority field second.
- R4: When pending requests have equal priority words, the lowest source index wins.
- R5: A group value g from 0 to 4 assigns the upper g bits of the priority word to the preemption field. Values 5 to 7 act as 4. Group 0 has no preemption levels, and every request then waits for the active handler to finish.
- R6: A pending winner is taken while a handler is active only if its preemption field is numerically smaller than that of the active handler. Equal preemption waits, even when the sub-priority is better. When no handler is active, any pending winner is taken.
- R7: `take_o` is a single-cycle pulse. `take_idx_o` gives the winning source in that cycle, and that source's pending bit is clear from the next cycle onward.
- R8: Each `done_i` pulse while a handler is active ends the innermost handler. Arbitration then resumes against the restored level, which is the thread level once the stack is empty.
- R9: At most 5 handlers can be nested. While 5 are active, no request is taken until one completes.
- R10: Changes on `grp_i` take effect one cycle after the stack is empty. While any handler is active the previous setting stays in force.
- R11: A `done_i` pulse while no handler is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request lines, sampled as levels |
| prio_i | input | 32 | Priority word per source; source k uses bits [4k+3:4k] |
| grp_i | input | 3 | Group setting: number of preemption bits |
| done_i | input | 1 | Handler-complete strobe |
| take_o | output | 1 | One-cycle pulse when a request is accepted |
| take_idx_o | output | 3 | Index of the accepted source |

## Verification
The assertions assume that `done_i` is raised only for a handler the bench has actually entered. They expect the push check to fire only in cycles without a completion strobe, and they expect each priority word to stay fixed while its source is pending. The stimulus follows these rules. It changes the priority inputs only while no source is pending, pulses each request line for a single cycle, and raises `done_i` only in cycles where no take pulse is expected. The one exception is a strobe sent while idle, which is used on purpose to exercise R11.

// File: rtl/grp_irq_pkg.sv
`timescale 1ns/1ps
package grp_irq_pkg;
  localparam int PRIO_W = 4;
  localparam int GRP_W  = 3;
  localparam int LVL_W  = PRIO_W + 1;
  localparam logic [LVL_W-1:0] LVL_BASE = {1'b1, {PRIO_W{1'b0}}};

  typedef logic [LVL_W-1:0] lvl_t;

  // upper g bits set; g above PRIO_W saturates
  function automatic logic [PRIO_W-1:0] pre_mask(logic [GRP_W-1:0] g);
    logic [PRIO_W-1:0] m;
    m = '0;
    for (int b = 0; b < PRIO_W; b++)
      if (b >= PRIO_W - int'(g)) m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/grp_irq_pend.sv
`timescale 1ns/1ps
module grp_irq_pend #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q | req_i) & ~clr_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/grp_irq_pick.sv
`timescale 1ns/1ps
module grp_irq_pick #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    vld_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [PRIO_W-1:0]       prio_o
);
  // full-word compare = preemption then sub-priority; strict < keeps lowest index
  always_comb begin
    vld_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend_i[i] && (!vld_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
        vld_o  = 1'b1;
        idx_o  = IDX_W'(i);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/grp_irq_stack.sv
`timescale 1ns/1ps
module grp_irq_stack
  import grp_irq_pkg::*;
#(
  parameter int STACK_D = 5,
  localparam int DEP_W  = $clog2(STACK_D + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  lvl_t             push_lvl_i,
  output lvl_t             top_o,
  output logic [DEP_W-1:0] depth_o,
  output logic             full_o
);
  lvl_t             lvl_q [STACK_D];
  logic [DEP_W-1:0] depth_q;
  logic             pop_ok;

  assign pop_ok = pop_i && (depth_q != '0);

  always_comb begin
    top_o = LVL_BASE;
    for (int i = 0; i < STACK_D; i++)
      if (int'(depth_q) == i + 1) top_o = lvl_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < STACK_D; i++) lvl_q[i] <= LVL_BASE;
    end else if (push_i && pop_ok) begin
      for (int i = 0; i < STACK_D; i++)
        if (int'(depth_q) == i + 1) lvl_q[i] <= push_lvl_i;
    end else if (push_i) begin
      for (int i = 0; i < STACK_D; i++)
        if (int'(depth_q) == i) lvl_q[i] <= push_lvl_i;
      depth_q <= depth_q + 1'b1;
    end else if (pop_ok) begin
      depth_q <= depth_q - 1'b1;
    end
  end

  assign depth_o = depth_q;
  assign full_o  = (int'(depth_q) == STACK_D);
endmodule

// File: rtl/grp_irq_arb.sv
`timescale 1ns/1ps
module grp_irq_arb
  import grp_irq_pkg::*;
#(
  parameter int N_SRC   = 8,
  parameter int STACK_D = 5,
  localparam int IDX_W  = $clog2(N_SRC),
  localparam int DEP_W  = $clog2(STACK_D + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [GRP_W-1:0]        grp_i,
  input  logic                    done_i,
  output logic                    take_o,
  output logic [IDX_W-1:0]        take_idx_o
);
  logic [N_SRC-1:0]  pend_q, clr_vec;
  logic              win_vld, full;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;
  lvl_t              win_lvl, cur_lvl;
  logic [DEP_W-1:0]  depth_q;
  logic [GRP_W-1:0]  grp_q;

  grp_irq_pend #(.N_SRC(N_SRC)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .clr_i(clr_vec), .pend_o(pend_q)
  );

  grp_irq_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pick (
    .pend_i(pend_q), .prio_i(prio_i), .vld_o(win_vld), .idx_o(win_idx), .prio_o(win_prio)
  );

  grp_irq_stack #(.STACK_D(STACK_D)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(take_o), .pop_i(done_i),
    .push_lvl_i(win_lvl), .top_o(cur_lvl), .depth_o(depth_q), .full_o(full)
  );

  // grouping only follows grp_i with no handler active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              grp_q <= '0;
    else if (depth_q == '0)   grp_q <= grp_i;
  end

  assign win_lvl    = {1'b0, win_prio & pre_mask(grp_q)};
  assign take_o     = win_vld && !full && (win_lvl < cur_lvl);
  assign take_idx_o = win_idx;

  always_comb begin
    clr_vec = '0;
    if (take_o) clr_vec[win_idx] = 1'b1;
  end
endmodule

// File: rtl/grp_irq_chk.sv
`timescale 1ns/1ps
module grp_irq_chk
  import grp_irq_pkg::*;
#(
  parameter int N_SRC   = 8,
  parameter int STACK_D = 5,
  localparam int IDX_W  = $clog2(N_SRC),
  localparam int DEP_W  = $clog2(STACK_D + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_i,
  input logic             take_o,
  input logic [IDX_W-1:0] take_idx_o,
  input logic [N_SRC-1:0] pend_q,
  input logic [DEP_W-1:0] depth_q,
  input lvl_t             cur_lvl,
  input logic [GRP_W-1:0] grp_q
);
  p_take_pending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> pend_q[take_idx_o]);

  p_take_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !pend_q[$past(take_idx_o)]);

  p_preempt_strict_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !done_i) |=> (cur_lvl < $past(cur_lvl)));

  p_push_depth_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !done_i) |=> (depth_q == $past(depth_q) + 1'b1));

  p_pop_depth_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !take_o && depth_q != '0) |=> (depth_q == $past(depth_q) - 1'b1));

  p_idle_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !take_o && depth_q == '0) |=> (depth_q == '0));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(depth_q) <= STACK_D);

  p_grp_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_q != '0) |=> $stable(grp_q));
endmodule

bind grp_irq_arb grp_irq_chk #(.N_SRC(N_SRC), .STACK_D(STACK_D)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .take_o(take_o),
  .take_idx_o(take_idx_o), .pend_q(pend_q), .depth_q(depth_q),
  .cur_lvl(cur_lvl), .grp_q(grp_q)
);

// File: tb/grp_irq_arb_bench.sv
`timescale 1ns/1ps
module grp_irq_arb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic [31:0] prio = '0;
  logic [2:0]  grp = '0;
  logic        done = 1'b0;
  logic        take;
  logic [2:0]  tidx;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  grp_irq_arb u_grp_irq_arb (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .prio_i(prio), .grp_i(grp),
    .done_i(done), .take_o(take), .take_idx_o(tidx)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lvl(input int p, input int g);
    int ge = (g > 4) ? 4 : g;
    return (ge == 0) ? 0 : (p >> (4 - ge));
  endfunction

  function automatic void set_p(input int k, input int v);
    prio[k*4 +: 4] = 4'(v);
  endfunction

  task automatic pulse_req(input int s);
    req[s] = 1'b1; tick(); req[s] = 1'b0; #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // handler for src 3 active, src 5 arrives
  task automatic run_pair(input int g, input int pa, input int pb);
    bit exp;
    grp = 3'(g); tick();
    set_p(3, pa); set_p(5, pb);
    pulse_req(3);
    chk(take && tidx == 3, "R7 take first", int'(tidx), 3);
    tick(); #1;
    chk(!take, "R7 single pulse", int'(take), 0);
    pulse_req(5);
    exp = lvl(pb, g) < lvl(pa, g);
    chk(take == exp, "R6/R5 preempt decision", int'(take), int'(exp));
    if (exp) begin
      chk(tidx == 5, "R6 preempt index", int'(tidx), 5);
      tick(); done = 1'b1; tick(); tick(); done = 1'b0;
    end else begin
      done = 1'b1; tick(); done = 1'b0; #1;
      chk(take && tidx == 5, "R8/R2 resume after done", int'(take), 1);
      tick(); done = 1'b1; tick(); done = 1'b0;
    end
  endtask

  // all eight pending together: serviced in priority order
  task automatic run_all(input int g, input int seed);
    int pv [8];
    bit [7:0] rem = 8'hFF;
    grp = 3'(g); tick();
    for (int k = 0; k < 8; k++) begin
      pv[k] = ((seed * 5 + k * 3) ^ (k * seed)) & ((seed % 2 == 1) ? 3 : 15);
      set_p(k, pv[k]);
    end
    req = 8'hFF; tick(); req = '0; #1;
    for (int n = 0; n < 8; n++) begin
      int e = -1;
      for (int k = 0; k < 8; k++)
        if (rem[k] && (e < 0 || pv[k] < pv[e])) e = k;
      chk(take && int'(tidx) == e, "R3/R4 winner order", int'(tidx), e);
      rem[e] = 1'b0;
      tick(); #1;
      chk(!take, "R6 lower ranked waits", int'(take), 0);
      done = 1'b1; tick(); done = 1'b0; #1;
    end
    chk(!take, "R2 all served", int'(take), 0);
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(); tick();
    #1;
    chk(!take, "R1 reset take low", int'(take), 0);
    rst_n = 1'b1;
    tick();
    chk(!take, "R1 nothing pending", int'(take), 0);

    // R11: idle done, then a lowest priority request still enters
    grp = 3'd4; tick();
    done = 1'b1; tick(); done = 1'b0;
    set_p(0, 15); pulse_req(0);
    chk(take && tidx == 0, "R11 idle done ignored", int'(take), 1);
    tick(); done = 1'b1; tick(); done = 1'b0;

    for (int g = 0; g < 8; g++)
      for (int pa = 0; pa < 16; pa++)
        for (int pb = 0; pb < 16; pb++)
          run_pair(g, pa, pb);

    for (int g = 0; g < 5; g++)
      for (int s = 0; s < 16; s++)
        run_all(g, s);

    // R9: five nested levels, sixth refused until one completes
    grp = 3'd4; tick();
    for (int k = 0; k < 5; k++) begin
      set_p(k, 7 - k);
      pulse_req(k);
      chk(take && int'(tidx) == k, "R9 nest level", int'(tidx), k);
      tick();
    end
    set_p(5, 0);
    pulse_req(5);
    chk(!take, "R9 full stack blocks", int'(take), 0);
    done = 1'b1; tick(); done = 1'b0; #1;
    chk(take && tidx == 5, "R9 taken after pop", int'(tidx), 5);
    tick();
    done = 1'b1;
    for (int k = 0; k < 5; k++) tick();
    done = 1'b0;

    // R10: group change while active has no effect
    grp = 3'd4; tick();
    set_p(2, 8); set_p(6, 4);
    pulse_req(2);
    chk(take && tidx == 2, "R10 enter handler", int'(tidx), 2);
    tick();
    grp = 3'd0; tick();
    pulse_req(6);
    chk(take && tidx == 6, "R10 old group kept", int'(take), 1);
    tick(); done = 1'b1; tick(); tick(); done = 1'b0;
    tick();
    pulse_req(2);
    chk(take && tidx == 2, "R10 reenter", int'(tidx), 2);
    tick();
    pulse_req(6);
    chk(!take, "R10 new group applied when idle", int'(take), 0);
    done = 1'b1; tick(); done = 1'b0; #1;
    chk(take && tidx == 6, "R10 resume", int'(tidx), 6);
    tick(); done = 1'b1; tick(); done = 1'b0;

    finish_run();
  end
endmodule